// File: doc/BRIEF.md
# Configuration Cycle Address Translator

This block turns a CPU access that lands in the south-side configuration window into the address of a PCI type-0 configuration cycle. It joins the 16 low access-address bits with a 16-bit upper-address value supplied by a mapping register. The upper part of that joined value carries a one-hot device-select field. The block finds the lowest set bit in that field and uses its position as the device number. It then builds a bus/device/function/register address with the enable bit set.

Accesses of byte, halfword and word size pass through a single registered output stage with a valid/ready handshake. An access is rejected when type-1 mode is selected, when the device-select field is empty, when it is misaligned, or when its size code is reserved. A rejected access still reaches the output, but it is marked as dropped: downstream logic discards a dropped write and returns the supplied all-ones fill value for a dropped read. Each access that is not rejected also sends a one-cycle strobe that clears the received master-abort and target-abort status bits of the bridge.

Top module: `pcx_cfg_xlate`

## Requirements
- R1: The joined address is `{map_upper, req_addr}`. Output bits [10:8] carry the function (joined bits [10:8]), [7:2] the register (joined bits [7:2]) and [1:0] the byte offset (joined bits [1:0]); bits [30:24] are zero.
- R2: Output bits [15:11] hold the index of the lowest set bit of joined bits [31:11] (index 0 is joined bit 11), so the largest value is 20.
- R3: An accepted cycle has output bit 31 set and `bus_num` in bits [23:16].
- R4: With `map_type1` = 1 every access is rejected.
- R5: An access whose joined bits [31:11] are all zero is rejected and sets `err_sticky`, which stays at 1 until reset.
- R6: Size codes are 0 byte, 1 halfword, 2 word, 3 reserved. A halfword with `req_addr[0]`=1, a word with `req_addr[1:0]`≠0, and any access with size code 3 are rejected.
- R7: A rejected access shows `cyc_drop`=1 and `cyc_addr`=0. Its `cyc_fill` is 0xFF for a byte read, 0xFFFF for a halfword read, 0xFFFFFFFF for a word or reserved-size read, and 0 for any write. An accepted access shows `cyc_drop`=0 and `cyc_fill`=0.
- R8: `sts_clr` is high for exactly one cycle per accepted access, in the first cycle that access is shown on the output; a rejected access never raises it.
- R9: `req_ready` is high when the output holds nothing or `cyc_ready` is high. A result appears in the cycle after its handshake, and while `cyc_valid`=1 and `cyc_ready`=0 all output fields keep their values.
- R10: After reset `cyc_valid`, `sts_clr` and `err_sticky` are 0. Write direction, size and write data pass through to `cyc_write`, `cyc_size` and `cyc_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 16 | Low window address bits |
| req_wdata | input | 32 | Write data |
| map_upper | input | 16 | Upper half of the joined address |
| map_type1 | input | 1 | Type-1 select (unsupported, rejects) |
| bus_num | input | 8 | Bus number placed in the output address |
| cyc_valid | output | 1 | Translated cycle present |
| cyc_ready | input | 1 | Consumer takes the cycle |
| cyc_addr | output | 32 | Configuration cycle address |
| cyc_write | output | 1 | Direction of the cycle |
| cyc_size | output | 2 | Size code of the cycle |
| cyc_wdata | output | 32 | Write data of the cycle |
| cyc_drop | output | 1 | Access rejected |
| cyc_fill | output | 32 | Read data to return for a rejected read |
| sts_clr | output | 1 | Abort-status clear strobe |
| err_sticky | output | 1 | Empty device-select seen since reset |

## Verification
The bench uses the default widths: a 16-bit low address, a 16-bit upper value, and a device-select field that starts at bit 11. With these widths the select field is 21 bits wide. This makes the lowest position (device 0), a middle position in the upper value (device 6) and the top position (device 20) all reachable from the ports. It also lets a field with several bits set show that the lowest bit wins. The 8-bit bus number is fixed to a value whose bits do not overlap any other field, so a misplaced bus field shows up as a wrong address.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

   localparam int CYC_W = 32;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } pcx_size_e;

   typedef struct packed {
      logic             drop;
      logic             sel_empty;
      logic [CYC_W-1:0] addr;
      logic [CYC_W-1:0] fill;
   } pcx_xlate_t;

endpackage

// File: rtl/pcx_lowbit_enc.sv
module pcx_lowbit_enc #(
   parameter int IN_W  = 21,
   parameter int OUT_W = 5
) (
   input  logic [IN_W-1:0]  vec,
   output logic [OUT_W-1:0] idx,
   output logic             none
);

   if (IN_W > (1 << OUT_W)) begin : g_bad_width
      $error("pcx_lowbit_enc: OUT_W too small for IN_W");
   end

   function automatic logic [IN_W-1:0] bit_mask(input int b);
      logic [IN_W-1:0] m;
      for (int i = 0; i < IN_W; i++) m[i] = ((i >> b) & 1) != 0;
      return m;
   endfunction

   logic [IN_W-1:0] iso;

   // isolate the lowest set bit
   assign iso  = vec & (~vec + {{(IN_W-1){1'b0}}, 1'b1});
   assign none = ~|vec;

   for (genvar b = 0; b < OUT_W; b++) begin : g_idx
      assign idx[b] = |(iso & bit_mask(b));
   end

endmodule

// File: rtl/pcx_field_decode.sv
module pcx_field_decode
   import pcx_pkg::*;
#(
   parameter int LO_W      = 16,
   parameter int UP_W      = 16,
   parameter int SEL_LSB   = 11,
   parameter int FN_LSB    = 8,
   parameter int BUS_LSB   = 16,
   parameter int BUS_W     = 8,
   parameter int DEV_W     = 5
) (
   input  logic [LO_W-1:0]  req_addr,
   input  logic [1:0]       req_size,
   input  logic             req_write,
   input  logic [UP_W-1:0]  map_upper,
   input  logic             map_type1,
   input  logic [BUS_W-1:0] bus_num,
   output pcx_xlate_t       res
);

   localparam int JOIN_W = LO_W + UP_W;
   localparam int SEL_W  = JOIN_W - SEL_LSB;

   if (JOIN_W != CYC_W) begin : g_bad_join
      $error("pcx_field_decode: joined width must equal cycle width");
   end
   if (BUS_LSB + BUS_W > CYC_W - 1 || SEL_LSB + DEV_W > BUS_LSB) begin : g_bad_layout
      $error("pcx_field_decode: output fields overlap");
   end

   logic [JOIN_W-1:0] joined;
   logic [DEV_W-1:0]  dev;
   logic              sel_none;
   logic              misalign;
   logic              reject;
   pcx_size_e         sz;

   assign joined = {map_upper, req_addr};
   assign sz     = pcx_size_e'(req_size);

   pcx_lowbit_enc #(.IN_W(SEL_W), .OUT_W(DEV_W)) u_enc (
      .vec  (joined[JOIN_W-1:SEL_LSB]),
      .idx  (dev),
      .none (sel_none)
   );

   always_comb begin
      unique case (sz)
         SZ_BYTE: misalign = 1'b0;
         SZ_HALF: misalign = req_addr[0];
         SZ_WORD: misalign = |req_addr[1:0];
         default: misalign = 1'b1;
      endcase
   end

   assign reject = map_type1 | sel_none | misalign;

   always_comb begin
      res           = '0;
      res.drop      = reject;
      res.sel_empty = sel_none;
      if (!reject) begin
         res.addr[CYC_W-1]              = 1'b1;
         res.addr[BUS_LSB +: BUS_W]     = bus_num;
         res.addr[SEL_LSB +: DEV_W]     = dev;
         res.addr[SEL_LSB-1:FN_LSB]     = joined[SEL_LSB-1:FN_LSB];
         res.addr[FN_LSB-1:0]           = joined[FN_LSB-1:0];
      end else if (!req_write) begin
         unique case (sz)
            SZ_BYTE: res.fill = {{(CYC_W-8){1'b0}}, 8'hFF};
            SZ_HALF: res.fill = {{(CYC_W-16){1'b0}}, 16'hFFFF};
            default: res.fill = '1;
         endcase
      end
   end

endmodule

// File: rtl/pcx_out_stage.sv
module pcx_out_stage
   import pcx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [1:0]       req_size,
   input  logic [CYC_W-1:0] req_wdata,
   input  pcx_xlate_t       res,
   output logic             cyc_valid,
   input  logic             cyc_ready,
   output logic [CYC_W-1:0] cyc_addr,
   output logic             cyc_write,
   output logic [1:0]       cyc_size,
   output logic [CYC_W-1:0] cyc_wdata,
   output logic             cyc_drop,
   output logic [CYC_W-1:0] cyc_fill,
   output logic             sts_clr,
   output logic             err_sticky
);

   logic load;

   assign req_ready = ~cyc_valid | cyc_ready;
   assign load      = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_valid  <= 1'b0;
         sts_clr    <= 1'b0;
         err_sticky <= 1'b0;
      end else begin
         if (load)           cyc_valid <= 1'b1;
         else if (cyc_ready) cyc_valid <= 1'b0;
         sts_clr    <= load & ~res.drop;
         err_sticky <= err_sticky | (load & res.sel_empty);
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         cyc_addr  <= res.addr;
         cyc_fill  <= res.fill;
         cyc_drop  <= res.drop;
         cyc_write <= req_write;
         cyc_size  <= req_size;
         cyc_wdata <= req_wdata;
      end
   end

endmodule

// File: rtl/pcx_cfg_xlate.sv
module pcx_cfg_xlate
   import pcx_pkg::*;
#(
   parameter int LO_W    = 16,
   parameter int UP_W    = 16,
   parameter int SEL_LSB = 11,
   parameter int FN_LSB  = 8,
   parameter int BUS_LSB = 16,
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [1:0]       req_size,
   input  logic [LO_W-1:0]  req_addr,
   input  logic [31:0]      req_wdata,
   input  logic [UP_W-1:0]  map_upper,
   input  logic             map_type1,
   input  logic [BUS_W-1:0] bus_num,
   output logic             cyc_valid,
   input  logic             cyc_ready,
   output logic [31:0]      cyc_addr,
   output logic             cyc_write,
   output logic [1:0]       cyc_size,
   output logic [31:0]      cyc_wdata,
   output logic             cyc_drop,
   output logic [31:0]      cyc_fill,
   output logic             sts_clr,
   output logic             err_sticky
);

   if (FN_LSB < 2 || FN_LSB >= SEL_LSB) begin : g_bad_fn
      $error("pcx_cfg_xlate: function field position invalid");
   end

   pcx_xlate_t res;

   pcx_field_decode #(
      .LO_W(LO_W), .UP_W(UP_W), .SEL_LSB(SEL_LSB), .FN_LSB(FN_LSB),
      .BUS_LSB(BUS_LSB), .BUS_W(BUS_W), .DEV_W(DEV_W)
   ) u_dec (
      .req_addr  (req_addr),
      .req_size  (req_size),
      .req_write (req_write),
      .map_upper (map_upper),
      .map_type1 (map_type1),
      .bus_num   (bus_num),
      .res       (res)
   );

   pcx_out_stage u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_size   (req_size),
      .req_wdata  (req_wdata),
      .res        (res),
      .cyc_valid  (cyc_valid),
      .cyc_ready  (cyc_ready),
      .cyc_addr   (cyc_addr),
      .cyc_write  (cyc_write),
      .cyc_size   (cyc_size),
      .cyc_wdata  (cyc_wdata),
      .cyc_drop   (cyc_drop),
      .cyc_fill   (cyc_fill),
      .sts_clr    (sts_clr),
      .err_sticky (err_sticky)
   );

endmodule

// File: rtl/pcx_cfg_xlate_chk.sv
module pcx_cfg_xlate_chk #(
   parameter int MAX_DEV = 20
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cyc_valid,
   input logic        cyc_ready,
   input logic [31:0] cyc_addr,
   input logic        cyc_drop,
   input logic [31:0] cyc_fill,
   input logic        sts_clr,
   input logic        err_sticky
);

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_addr)
                                  && $stable(cyc_drop) && $stable(cyc_fill));

   // R9
   stall_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid && !cyc_ready |=> !sts_clr);

   // R8
   strobe_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_clr |-> cyc_valid && !cyc_drop);

   // R5
   err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

   // R3
   enable_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid && !cyc_drop |-> cyc_addr[31] && cyc_fill == 32'h0);

   // R7
   drop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid && cyc_drop |-> cyc_addr == 32'h0);

   // R2
   dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid && !cyc_drop |-> int'(cyc_addr[15:11]) <= MAX_DEV);

endmodule

bind pcx_cfg_xlate pcx_cfg_xlate_chk #(.MAX_DEV(LO_W + UP_W - SEL_LSB - 1)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_valid  (cyc_valid),
   .cyc_ready  (cyc_ready),
   .cyc_addr   (cyc_addr),
   .cyc_drop   (cyc_drop),
   .cyc_fill   (cyc_fill),
   .sts_clr    (sts_clr),
   .err_sticky (err_sticky)
);

// File: tb/tb_pcx_cfg_xlate.sv
module tb_pcx_cfg_xlate;

   typedef struct packed {
      logic        t1;
      logic [15:0] up;
      logic [15:0] a;
      logic [1:0]  sz;
      logic        wr;
      logic        drop;
      logic [31:0] eaddr;
      logic [31:0] efill;
   } vec_t;

   // R1 R2 R3 R4 R6 R7 table
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'h0000, 16'h0800, 2'd2, 1'b0, 1'b0, 32'h803A0000, 32'h0},
      '{1'b0, 16'h0000, 16'h35A4, 2'd2, 1'b0, 1'b0, 32'h803A0DA4, 32'h0},
      '{1'b0, 16'h0002, 16'h0102, 2'd1, 1'b1, 1'b0, 32'h803A3102, 32'h0},
      '{1'b0, 16'h8000, 16'h0003, 2'd0, 1'b0, 1'b0, 32'h803AA003, 32'h0},
      '{1'b0, 16'h0010, 16'hFFFC, 2'd2, 1'b0, 1'b0, 32'h803A07FC, 32'h0},
      '{1'b1, 16'h0001, 16'h0000, 2'd2, 1'b0, 1'b1, 32'h0, 32'hFFFFFFFF},
      '{1'b1, 16'h0001, 16'h0000, 2'd0, 1'b0, 1'b1, 32'h0, 32'h000000FF},
      '{1'b0, 16'h0001, 16'h0001, 2'd1, 1'b0, 1'b1, 32'h0, 32'h0000FFFF},
      '{1'b0, 16'h0001, 16'h0002, 2'd2, 1'b1, 1'b1, 32'h0, 32'h0},
      '{1'b0, 16'h0001, 16'h0000, 2'd3, 1'b0, 1'b1, 32'h0, 32'hFFFFFFFF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, map_type1 = 1'b0, cyc_ready = 1'b1;
   logic [1:0]  req_size = 2'd0;
   logic [15:0] req_addr = '0, map_upper = '0;
   logic [31:0] req_wdata = '0;
   logic [7:0]  bus_num = 8'h3A;
   logic        req_ready, cyc_valid, cyc_write, cyc_drop, sts_clr, err_sticky;
   logic [1:0]  cyc_size;
   logic [31:0] cyc_addr, cyc_wdata, cyc_fill;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pcx_cfg_xlate dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic [31:0] wd);
      @(negedge clk);
      map_type1 = v.t1; map_upper = v.up; req_addr = v.a;
      req_size = v.sz; req_write = v.wr; req_wdata = wd; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 valid at reset", {31'h0, cyc_valid}, 32'h0);
      chk("R10 strobe at reset", {31'h0, sts_clr}, 32'h0);
      chk("R10 err at reset", {31'h0, err_sticky}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 ready when empty", {31'h0, req_ready}, 32'h1);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i], 32'hC0DE0000 + i);
         chk($sformatf("R9 valid v%0d", i), {31'h0, cyc_valid}, 32'h1);
         chk($sformatf("R7 drop v%0d", i), {31'h0, cyc_drop}, {31'h0, VECS[i].drop});
         chk($sformatf("R1 R2 R3 addr v%0d", i), cyc_addr, VECS[i].eaddr);
         chk($sformatf("R7 fill v%0d", i), cyc_fill, VECS[i].efill);
         chk($sformatf("R8 strobe v%0d", i), {31'h0, sts_clr}, {31'h0, ~VECS[i].drop});
         chk($sformatf("R10 pass v%0d", i), {29'h0, cyc_write, cyc_size},
             {29'h0, VECS[i].wr, VECS[i].sz});
         chk($sformatf("R10 wdata v%0d", i), cyc_wdata, 32'hC0DE0000 + i);
         @(negedge clk);
         chk($sformatf("R8 strobe one cycle v%0d", i), {31'h0, sts_clr}, 32'h0);
         chk($sformatf("R9 drained v%0d", i), {31'h0, cyc_valid}, 32'h0);
      end

      // R9 stall: output held, second request refused
      cyc_ready = 1'b0;
      drive(VECS[1], 32'h1);
      chk("R9 stall addr", cyc_addr, 32'h803A0DA4);
      chk("R8 stall strobe", {31'h0, sts_clr}, 32'h1);
      map_upper = 16'h8000; req_addr = 16'h0003; req_size = 2'd0; req_valid = 1'b1;
      @(negedge clk);
      chk("R9 ready low in stall", {31'h0, req_ready}, 32'h0);
      chk("R9 held addr", cyc_addr, 32'h803A0DA4);
      chk("R8 no second strobe", {31'h0, sts_clr}, 32'h0);
      cyc_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 next after release", cyc_addr, 32'h803AA003);
      chk("R8 strobe after release", {31'h0, sts_clr}, 32'h1);
      @(negedge clk);

      // R5 empty device-select field
      chk("R5 err before", {31'h0, err_sticky}, 32'h0);
      drive('{1'b0, 16'h0000, 16'h0040, 2'd0, 1'b0, 1'b1, 32'h0, 32'hFF}, 32'h0);
      chk("R5 empty sel drop", {31'h0, cyc_drop}, 32'h1);
      chk("R5 empty sel fill", cyc_fill, 32'h000000FF);
      chk("R5 empty sel strobe", {31'h0, sts_clr}, 32'h0);
      chk("R5 err set", {31'h0, err_sticky}, 32'h1);
      drive(VECS[0], 32'h0);
      chk("R5 err held", {31'h0, err_sticky}, 32'h1);
      chk("R3 good after err", cyc_addr, 32'h803A0000);
      @(negedge clk);

      // R10 reset clears sticky
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 err cleared", {31'h0, err_sticky}, 32'h0);
      chk("R10 valid cleared", {31'h0, cyc_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule